// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Chain

This block holds the digital division path of an integer-N frequency synthesizer. One divider counts reference-clock events and produces a one-cycle pulse at the start of every reference period. A second path counts events from the RF input through a 64/65 two-modulus prescaler. Its main and swallow counters steer the prescaler through a modulus-control output, and it pulses once per feedback period. The two pulse trains go to a phase/frequency detector. A behavioural model of the prescaler is included, so the complete feedback division can be checked tick for tick.

All logic runs on one clock. Reference and RF events arrive as one-cycle tick enables. Software writes the three divide values together into holding registers. The reference value and the main/swallow pair are each checked for legality, and an illegal value is dropped. Each counter picks up the held value only when it reloads at its terminal count. A count in progress therefore always finishes with the values it started with.

Top module: `dmd_divider_chain`

## Requirements
- R1: `mod_ctl_o` low makes the prescaler wrap after 65 RF ticks, and high makes it wrap after 64. In each feedback frame `mod_ctl_o` stays low for the first A prescaler cycles (65·A ticks) and is high for the rest. It changes only on the cycle after a prescaler wrap.
- R2: `fv_o` pulses once every 64·N + A RF ticks, with N from 1 to 4095, A from 0 to 63 and N ≥ A. The largest ratio is 262,143.
- R3: `fr_o` pulses once every R reference ticks for any legal R: 1 or 5 to 8191. With R = 1 it pulses after every tick.
- R4: A written R of 0, 2, 3 or 4 is discarded and the previously held R stays in use.
- R5: A written main/swallow pair with N = 0 or N < A is discarded and the previous pair stays in use. The R in the same write is judged on its own.
- R6: A write (`cfg_we_i` high for one cycle) updates the holding registers at that edge. A frame already running ends with its old values, and each counter uses the new values from its next reload onward.
- R7: While reset is asserted `fr_o` and `fv_o` are 0. The first frames after reset use R = 5, N = 2, A = 1, so `mod_ctl_o` is 0 out of reset.
- R8: `fr_o` and `fv_o` are registered one-cycle pulses. They rise on the edge that takes in the last tick of their count.
- R9: A cycle without its tick enable leaves the corresponding counters unchanged, so periods are measured in ticks and not in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One reference event in this cycle |
| vco_tick_i | input | 1 | One RF input event in this cycle |
| cfg_we_i | input | 1 | Write the three divide values into the holding registers |
| cfg_ref_i | input | 13 | Reference divide value R |
| cfg_main_i | input | 12 | Main counter value N |
| cfg_swal_i | input | 6 | Swallow counter value A |
| fr_o | output | 1 | Reference period pulse |
| fv_o | output | 1 | Feedback period pulse |
| mod_ctl_o | output | 1 | Prescaler modulus select (0: ÷65, 1: ÷64) |

## Verification
The feedback path runs with several pairs. With A = 0 the output must never go low. A small A against a larger N exercises the mixed ÷65/÷64 frame. N = A gives a frame that is ÷65 throughout. Near-maximum values with RF ticks dropped at random show that the count is kept in ticks and not in cycles. For each frame the bench records both the total tick count and the number of ticks spent at ÷65, so a wrong modulus sequence is caught even when the total happens to match. R is stepped through 7, 1 and 8191, interleaved with illegal R values and illegal pairs. The frame that is running when each write lands is checked to still use the old values.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  localparam int unsigned REF_W   = 13;  // reference divide width
  localparam int unsigned MAIN_W  = 12;  // main counter width
  localparam int unsigned SWAL_W  = 6;   // swallow width, prescaler base = 2**SWAL_W
  localparam int unsigned REF_MIN = 5;   // smallest legal R above 1
  localparam int unsigned REF_RST  = 5;
  localparam int unsigned MAIN_RST = 2;
  localparam int unsigned SWAL_RST = 1;
endpackage

// File: rtl/dmd_cfg_hold.sv
module dmd_cfg_hold #(
  parameter int unsigned REF_W    = dmd_pkg::REF_W,
  parameter int unsigned MAIN_W   = dmd_pkg::MAIN_W,
  parameter int unsigned SWAL_W   = dmd_pkg::SWAL_W,
  parameter int unsigned REF_MIN  = dmd_pkg::REF_MIN,
  parameter int unsigned REF_RST  = dmd_pkg::REF_RST,
  parameter int unsigned MAIN_RST = dmd_pkg::MAIN_RST,
  parameter int unsigned SWAL_RST = dmd_pkg::SWAL_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REF_W-1:0]  ref_i,
  input  logic [MAIN_W-1:0] main_i,
  input  logic [SWAL_W-1:0] swal_i,
  output logic [REF_W-1:0]  ref_o,
  output logic [MAIN_W-1:0] main_o,
  output logic [SWAL_W-1:0] swal_o
);
  logic ref_ok, pair_ok;

  assign ref_ok  = (ref_i == REF_W'(1)) || (ref_i >= REF_W'(REF_MIN));
  assign pair_ok = (main_i != '0) && (main_i >= MAIN_W'(swal_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o  <= REF_W'(REF_RST);
      main_o <= MAIN_W'(MAIN_RST);
      swal_o <= SWAL_W'(SWAL_RST);
    end else if (we_i) begin
      if (ref_ok) ref_o <= ref_i;
      if (pair_ok) begin
        main_o <= main_i;
        swal_o <= swal_i;
      end
    end
  end
endmodule

// File: rtl/dmd_ref_div.sv
module dmd_ref_div #(
  parameter int unsigned REF_W   = dmd_pkg::REF_W,
  parameter int unsigned REF_RST = dmd_pkg::REF_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [REF_W-1:0] div_i,
  output logic             pulse_o
);
  logic [REF_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= REF_W'(REF_RST);
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (tick_i) begin
        if (rem_q <= REF_W'(1)) begin
          rem_q   <= div_i;  // reload only at terminal count
          pulse_o <= 1'b1;
        end else begin
          rem_q <= rem_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
  parameter int unsigned SWAL_W = dmd_pkg::SWAL_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mod_ctl_i,
  output logic wrap_o
);
  localparam int unsigned CNT_W = SWAL_W + 1;
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'((1 << SWAL_W) - 1);  // /64
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(1 << SWAL_W);        // /65

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = mod_ctl_i ? LAST_HI : LAST_LO;
  assign wrap_o = tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dmd_swallow.sv
module dmd_swallow #(
  parameter int unsigned MAIN_W   = dmd_pkg::MAIN_W,
  parameter int unsigned SWAL_W   = dmd_pkg::SWAL_W,
  parameter int unsigned MAIN_RST = dmd_pkg::MAIN_RST,
  parameter int unsigned SWAL_RST = dmd_pkg::SWAL_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wrap_i,
  input  logic [MAIN_W-1:0] main_i,
  input  logic [SWAL_W-1:0] swal_i,
  output logic              pulse_o,
  output logic              mod_ctl_o
);
  logic [MAIN_W-1:0] main_rem_q;
  logic [SWAL_W-1:0] swal_rem_q;

  // /65 while swallow cycles remain
  assign mod_ctl_o = (swal_rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_rem_q <= MAIN_W'(MAIN_RST);
      swal_rem_q <= SWAL_W'(SWAL_RST);
      pulse_o    <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (wrap_i) begin
        if (main_rem_q <= MAIN_W'(1)) begin
          main_rem_q <= main_i;
          swal_rem_q <= swal_i;
          pulse_o    <= 1'b1;
        end else begin
          main_rem_q <= main_rem_q - 1'b1;
          if (swal_rem_q != '0) swal_rem_q <= swal_rem_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dmd_divider_chain.sv
module dmd_divider_chain #(
  parameter int unsigned REF_W    = dmd_pkg::REF_W,
  parameter int unsigned MAIN_W   = dmd_pkg::MAIN_W,
  parameter int unsigned SWAL_W   = dmd_pkg::SWAL_W,
  parameter int unsigned REF_MIN  = dmd_pkg::REF_MIN,
  parameter int unsigned REF_RST  = dmd_pkg::REF_RST,
  parameter int unsigned MAIN_RST = dmd_pkg::MAIN_RST,
  parameter int unsigned SWAL_RST = dmd_pkg::SWAL_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              vco_tick_i,
  input  logic              cfg_we_i,
  input  logic [REF_W-1:0]  cfg_ref_i,
  input  logic [MAIN_W-1:0] cfg_main_i,
  input  logic [SWAL_W-1:0] cfg_swal_i,
  output logic              fr_o,
  output logic              fv_o,
  output logic              mod_ctl_o
);
  logic [REF_W-1:0]  ref_held;
  logic [MAIN_W-1:0] main_held;
  logic [SWAL_W-1:0] swal_held;
  logic              pres_wrap;

  dmd_cfg_hold #(
    .REF_W(REF_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .REF_MIN(REF_MIN),
    .REF_RST(REF_RST), .MAIN_RST(MAIN_RST), .SWAL_RST(SWAL_RST)
  ) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .ref_i  (cfg_ref_i),
    .main_i (cfg_main_i),
    .swal_i (cfg_swal_i),
    .ref_o  (ref_held),
    .main_o (main_held),
    .swal_o (swal_held)
  );

  dmd_ref_div #(.REF_W(REF_W), .REF_RST(REF_RST)) u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (ref_tick_i),
    .div_i   (ref_held),
    .pulse_o (fr_o)
  );

  dmd_prescaler #(.SWAL_W(SWAL_W)) u_pres (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (vco_tick_i),
    .mod_ctl_i (mod_ctl_o),
    .wrap_o    (pres_wrap)
  );

  dmd_swallow #(
    .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MAIN_RST(MAIN_RST), .SWAL_RST(SWAL_RST)
  ) u_swal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (pres_wrap),
    .main_i    (main_held),
    .swal_i    (swal_held),
    .pulse_o   (fv_o),
    .mod_ctl_o (mod_ctl_o)
  );
endmodule

// File: rtl/dmd_divider_chain_chk.sv
module dmd_divider_chain_chk #(
  parameter int unsigned REF_W   = dmd_pkg::REF_W,
  parameter int unsigned REF_MIN = dmd_pkg::REF_MIN
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_tick_i,
  input logic             fr_o,
  input logic             fv_o,
  input logic             mod_ctl_o,
  input logic             pres_wrap_i,
  input logic [REF_W-1:0] ref_held_i
);
  a_r8_fv_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fv_o |=> !fv_o);

  a_r8_fr_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_o |-> $past(ref_tick_i));

  a_r2_fv_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fv_o |-> $past(pres_wrap_i));

  a_r1_mod_moves_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_ctl_o) |-> $past(pres_wrap_i));

  a_r4_ref_held_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_held_i == REF_W'(1)) || (ref_held_i >= REF_W'(REF_MIN)));
endmodule

bind dmd_divider_chain dmd_divider_chain_chk #(.REF_W(REF_W), .REF_MIN(REF_MIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_tick_i  (ref_tick_i),
  .fr_o        (fr_o),
  .fv_o        (fv_o),
  .mod_ctl_o   (mod_ctl_o),
  .pres_wrap_i (pres_wrap),
  .ref_held_i  (ref_held)
);

// File: tb/dmd_divider_chain_test.sv
module dmd_divider_chain_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  typedef struct {
    int unsigned period;
    int unsigned low;
    string       tag;
  } frame_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick_i = 1'b0;
  logic        vco_tick_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [12:0] cfg_ref_i = '0;
  logic [11:0] cfg_main_i = '0;
  logic [5:0]  cfg_swal_i = '0;
  logic        fr_o, fv_o, mod_ctl_o;

  int checks = 0;
  int fails  = 0;
  bit run = 1'b0, ref_pause = 1'b0, vco_rand = 1'b0, done = 1'b0;

  frame_t sb_q[$];
  frame_t cur;
  int unsigned ref_cur = 5, ref_next = 5;
  string ref_tag_cur = "R7", ref_tag_next = "R3";
  int unsigned vco_cnt = 0, low_cnt = 0, ref_cnt = 0;

  dmd_divider_chain uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .vco_tick_i(vco_tick_i),
    .cfg_we_i(cfg_we_i), .cfg_ref_i(cfg_ref_i), .cfg_main_i(cfg_main_i),
    .cfg_swal_i(cfg_swal_i), .fr_o(fr_o), .fv_o(fv_o), .mod_ctl_o(mod_ctl_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor and tick source: all at the falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      if (run) begin
        if (fv_o) begin
          if (sb_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected fv pulse", vco_cnt, 0);
          end else begin
            frame_t e;
            e = sb_q.pop_front();
            chk(vco_cnt == e.period, e.tag, "fv period ticks", vco_cnt, e.period);
            chk(low_cnt == e.low, "R1", "ticks at /65", low_cnt, e.low);
          end
          vco_cnt = 0;
          low_cnt = 0;
        end
        if (fr_o) begin
          chk(ref_cnt == ref_cur, ref_tag_cur, "fr period ticks", ref_cnt, ref_cur);
          ref_cur = ref_next;
          ref_tag_cur = ref_tag_next;
          ref_cnt = 0;
        end
        begin
          bit vt, rt;
          vt = vco_rand ? (($urandom % 4) != 0) : 1'b1;
          rt = !ref_pause;
          vco_tick_i = vt;
          ref_tick_i = rt;
          vco_cnt += vt;
          if (vt && !mod_ctl_o) low_cnt++;
          ref_cnt += rt;
        end
      end
    end
  end

  task automatic cfg_write(int r, int n, int a, int unsigned exp_r, frame_t nxt,
                           int nf, string rtag);
    wait (sb_q.size() == 0);
    @(posedge clk_i); #1;
    ref_pause = 1'b1;
    sb_q.push_back('{cur.period, cur.low, "R6"});  // frame in flight keeps old pair
    @(posedge clk_i); #1;
    cfg_we_i   = 1'b1;
    cfg_ref_i  = 13'(r);
    cfg_main_i = 12'(n);
    cfg_swal_i = 6'(a);
    ref_next     = exp_r;
    ref_tag_next = rtag;
    @(posedge clk_i); #1;
    cfg_we_i  = 1'b0;
    ref_pause = 1'b0;
    for (int i = 0; i < nf; i++) sb_q.push_back(nxt);
    cur = nxt;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(fr_o == 1'b0, "R7", "fr_o in reset", fr_o, 0);
    chk(fv_o == 1'b0, "R7", "fv_o in reset", fv_o, 0);
    chk(mod_ctl_o == 1'b0, "R7", "mod_ctl_o in reset (A=1)", mod_ctl_o, 0);
    cur = '{129, 65, "R2"};
    sb_q.push_back('{129, 65, "R7"});
    sb_q.push_back(cur);
    sb_q.push_back(cur);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    run    = 1'b1;

    cfg_write(7, 3, 2, 7, '{194, 130, "R2"}, 3, "R3");
    cfg_write(1, 2, 0, 1, '{128, 0, "R1"}, 3, "R3");
    cfg_write(3, 3, 3, 1, '{195, 195, "R1"}, 3, "R4");   // R=3 dropped
    cfg_write(0, 1, 5, 1, '{195, 195, "R5"}, 3, "R4");   // R=0 and N<A dropped
    vco_rand = 1'b1;
    cfg_write(5, 64, 63, 5, '{4159, 4095, "R9"}, 2, "R3");
    wait (sb_q.size() == 0);
    vco_rand = 1'b0;
    cfg_write(8191, 300, 10, 8191, '{19210, 650, "R2"}, 2, "R3");
    wait (sb_q.size() == 0);
    @(posedge clk_i); #1;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end
endmodule